// File: doc/BRIEF.md
# Phase Detector with Lock Indicator

This block compares the rising edges of two divided clocks, a reference divider output and a main (feedback) divider output, and turns their arrival-time difference into a steering pulse for a loop filter. When the reference edge comes first, a source pulse (`up`) is raised until the main edge arrives. When the main edge comes first, a sink pulse (`dn`) is raised until the reference edge arrives. The pulse width, measured in cycles of a fast sampling clock, is the phase error of that comparison.

A lock monitor counts the width of each comparison's pulse. After each comparison it decides whether the error was inside a window of `LOCK_WIN` sampling cycles. That window stands for an error of roughly 25 ns at the chosen sampling rate. The monitor can be switched off, which forces the lock flag high. The detector runs only while both the power pin and the programmed power bit are high. Switching it off stops new pulses from starting, but a pulse already running is always allowed to finish at full width.

Top module: `pd_lock_top`

## Requirements
- R1: While `rst_n` is low, `up` and `dn` are low and the stored lock verdict is cleared, so `lock` is low when `lock_en` is high.
- R2: When a rising edge of `ref_div` is sampled with no rising edge of `main_div` in the same cycle, `up` goes high on the next cycle. It stays high until the clock edge that samples a rising edge of `main_div`. A gap of N cycles between the two sampled edges gives an `up` pulse exactly N cycles long.
- R3: The mirror case of R2: a lone sampled rising edge of `main_div` raises `dn` for exactly as many cycles as pass until a rising edge of `ref_div` is sampled.
- R4: Rising edges of both inputs sampled in the same cycle produce no pulse and count as a comparison with zero error.
- R5: `up` and `dn` are never high in the same cycle.
- R6: A further rising edge of the leading input, seen while its pulse is still running, is ignored. The pulse keeps running until the other input's edge arrives.
- R7: `lock` is updated on the cycle after each comparison ends and holds its value between comparisons. The stored verdict is high when the error width is less than `LOCK_WIN` cycles (default 2). It is low when the width is `LOCK_WIN` or more.
- R8: While `lock_en` is low, `lock` is high. When `lock_en` goes high again, `lock` shows the verdict of the most recent comparison.
- R9: While `pwr_pin` and `pwr_cfg` are not both high, no new pulse starts, and edges that arrive are not counted as comparisons.
- R10: If power is removed while a pulse is running, that pulse still ends at the opposite input's edge with its full width, and its verdict still updates `lock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock that measures error width |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Reference divider output, synchronous to `clk` |
| main_div | input | 1 | Main divider output, synchronous to `clk` |
| pwr_pin | input | 1 | Power-on input pin |
| pwr_cfg | input | 1 | Programmed power-on bit |
| lock_en | input | 1 | Lock monitor enable |
| up | output | 1 | Source pulse: reference edge leads |
| dn | output | 1 | Sink pulse: main edge leads |
| lock | output | 1 | Lock flag, high when in lock or when the monitor is disabled |

## Verification
The detector is driven with the reference leading by several gaps, with the main input leading, and with both edges sampled together. Together these separate correct polarity, exact width counting, and the zero-error path that raises no pulse. Gaps of one and two cycles sit on either side of the lock window, which shows whether the window comparison is strict. A second rising edge of the leading input inside a running pulse shows whether the pulse restarts or extends. Removing power mid-pulse, and then sending edges with power off, tells a synchronized shutdown apart from both a truncating one and one that keeps detecting.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Comparison state: waiting for an edge, sourcing, or sinking.
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_SRC  = 2'd1,
    PD_SNK  = 2'd2
  } pd_state_e;

  localparam int unsigned PD_NUM_INPUTS = 2;
  localparam int unsigned PD_IDX_REF    = 0;
  localparam int unsigned PD_IDX_MAIN   = 1;

endpackage

// File: rtl/pd_edge_det.sv
module pd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/pd_compare.sv
module pd_compare
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ref_rise_i,
  input  logic main_rise_i,
  output logic up_o,
  output logic dn_o,
  output logic busy_o,
  output logic done_o
);

  pd_state_e state_q;
  pd_state_e state_d;
  logic      done_d;

  // Next-state logic. New comparisons start only while powered; a running
  // pulse always runs to its closing edge, whatever the power inputs do.
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      PD_IDLE: begin
        if (active_i) begin
          if (ref_rise_i && main_rise_i) begin
            done_d = 1'b1;
          end else if (ref_rise_i) begin
            state_d = PD_SRC;
          end else if (main_rise_i) begin
            state_d = PD_SNK;
          end
        end
      end
      PD_SRC: begin
        if (main_rise_i) begin
          state_d = PD_IDLE;
          done_d  = 1'b1;
        end
      end
      PD_SNK: begin
        if (ref_rise_i) begin
          state_d = PD_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = PD_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign up_o   = (state_q == PD_SRC);
  assign dn_o   = (state_q == PD_SNK);
  assign busy_o = (state_q != PD_IDLE);
  assign done_o = done_d;

endmodule

// File: rtl/pd_lock_mon.sv
module pd_lock_mon #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LOCK_WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic done_i,
  input  logic lock_en_i,
  output logic lock_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] err_w;
  logic             lock_q;
  logic             lock_d;
  logic             lock_ce;

  // Saturating increment so a stuck pulse cannot wrap into a small error.
  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end

  // Width of the comparison that ends this cycle (zero for coincident edges).
  always_comb begin
    err_w = busy_i ? cnt_inc : '0;
  end

  always_comb begin
    cnt_d = (busy_i && !done_i) ? cnt_inc : '0;
  end

  always_comb begin
    lock_ce = done_i;
    lock_d  = (32'(err_w) < LOCK_WIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_ce) begin
      lock_q <= lock_d;
    end
  end

  assign lock_o = ~lock_en_i | lock_q;

endmodule

// File: rtl/pd_lock_top.sv
module pd_lock_top
  import pd_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LOCK_WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic main_div,
  input  logic pwr_pin,
  input  logic pwr_cfg,
  input  logic lock_en,
  output logic up,
  output logic dn,
  output logic lock
);

  logic [PD_NUM_INPUTS-1:0] div_in;
  logic [PD_NUM_INPUTS-1:0] div_rise;
  logic                     active;
  logic                     cmp_busy;
  logic                     cmp_done;

  assign div_in[PD_IDX_REF]  = ref_div;
  assign div_in[PD_IDX_MAIN] = main_div;
  assign active              = pwr_pin & pwr_cfg;

  for (genvar gi = 0; gi < PD_NUM_INPUTS; gi++) begin : g_edge
    pd_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (div_in[gi]),
      .rise_o (div_rise[gi])
    );
  end

  pd_compare u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .ref_rise_i  (div_rise[PD_IDX_REF]),
    .main_rise_i (div_rise[PD_IDX_MAIN]),
    .up_o        (up),
    .dn_o        (dn),
    .busy_o      (cmp_busy),
    .done_o      (cmp_done)
  );

  pd_lock_mon #(
    .CNT_W    (CNT_W),
    .LOCK_WIN (LOCK_WIN)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (cmp_busy),
    .done_i    (cmp_done),
    .lock_en_i (lock_en),
    .lock_o    (lock)
  );

endmodule

// File: rtl/pd_lock_chk.sv
module pd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_div,
  input logic main_div,
  input logic pwr_pin,
  input logic pwr_cfg,
  input logic up,
  input logic dn,
  input logic lock,
  input logic lock_en,
  input logic done
);

  // R5: never source and sink together
  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R2 and R10: a source pulse holds until the main input is high
  a_r2_src_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !main_div) |=> up);

  // R3 and R10: a sink pulse holds until the reference input is high
  a_r3_snk_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !ref_div) |=> dn);

  // R9: no source pulse starts while unpowered
  a_r9_no_new_src: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pwr_pin && pwr_cfg) && !up) |=> !up);

  // R9: no sink pulse starts while unpowered
  a_r9_no_new_snk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pwr_pin && pwr_cfg) && !dn) |=> !dn);

  // R7: lock moves only after a comparison ends or the enable changes
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lock_en) && !$past(done)) |-> $stable(lock));

  // R4: a coincident comparison leaves the flag high
  a_r4_coincident_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !up && !dn) |=> lock);

endmodule

bind pd_lock_top pd_lock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_div  (ref_div),
  .main_div (main_div),
  .pwr_pin  (pwr_pin),
  .pwr_cfg  (pwr_cfg),
  .up       (up),
  .dn       (dn),
  .lock     (lock),
  .lock_en  (lock_en),
  .done     (cmp_done)
);

// File: tb/sim_pd_lock_top.sv
`timescale 1ns/1ps
module sim_pd_lock_top;

  typedef struct {
    bit    is_up;
    int    width;
    string req;
  } pulse_t;

  logic clk;
  logic rst_n;
  logic ref_div;
  logic main_div;
  logic pwr_pin;
  logic pwr_cfg;
  logic lock_en;
  logic up;
  logic dn;
  logic lock;

  int     n_chk;
  int     n_err;
  bit     finished;
  pulse_t exp_q[$];

  pd_lock_top #(.CNT_W(8), .LOCK_WIN(2)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_div  (ref_div),
    .main_div (main_div),
    .pwr_pin  (pwr_pin),
    .pwr_cfg  (pwr_cfg),
    .lock_en  (lock_en),
    .up       (up),
    .dn       (dn),
    .lock     (lock)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // Monitor: measures each pulse at negedges and scores it against the queue.
  initial begin
    int up_run;
    int dn_run;
    pulse_t e;
    up_run = 0;
    dn_run = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        up_run = 0;
        dn_run = 0;
      end else begin
        if (up && dn) chk(1'b0, "R5", "up and dn both high", 1, 0);
        if (up) up_run++;
        else if (up_run > 0) begin
          if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected up pulse", up_run, 0);
          else begin
            e = exp_q.pop_front();
            chk(e.is_up == 1'b1, e.req, "pulse polarity up", 1, int'(e.is_up));
            chk(up_run == e.width, e.req, "up width", up_run, e.width);
          end
          up_run = 0;
        end
        if (dn) dn_run++;
        else if (dn_run > 0) begin
          if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected dn pulse", dn_run, 0);
          else begin
            e = exp_q.pop_front();
            chk(e.is_up == 1'b0, e.req, "pulse polarity dn", 0, int'(e.is_up));
            chk(dn_run == e.width, e.req, "dn width", dn_run, e.width);
          end
          dn_run = 0;
        end
      end
    end
  end

  // Driver: lead 0 = reference first, 1 = main first; gap in cycles.
  task automatic run_cmp(input int lead, input int gap, input bit exp_lock,
                         input string req);
    pulse_t e;
    e.is_up = (lead == 0);
    e.width = gap;
    e.req   = req;
    exp_q.push_back(e);
    if (lead == 0) ref_div = 1'b1; else main_div = 1'b1;
    repeat (gap) @(negedge clk);
    if (lead == 0) main_div = 1'b1; else ref_div = 1'b1;
    @(negedge clk);
    chk(lock == exp_lock, "R7", {req, " lock after comparison"}, int'(lock), int'(exp_lock));
    ref_div  = 1'b0;
    main_div = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    ref_div  = 1'b0;
    main_div = 1'b0;
    pwr_pin  = 1'b1;
    pwr_cfg  = 1'b1;
    lock_en  = 1'b1;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(up == 1'b0, "R1", "up in reset", int'(up), 0);
    chk(dn == 1'b0, "R1", "dn in reset", int'(dn), 0);
    chk(lock == 1'b0, "R1", "lock in reset", int'(lock), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: reference leads by 4, error too large
    run_cmp(0, 4, 1'b0, "R2");
    // R3: main leads by 3
    run_cmp(1, 3, 1'b0, "R3");

    // R4: coincident edges, no pulse, zero error locks
    ref_div  = 1'b1;
    main_div = 1'b1;
    @(negedge clk);
    chk(!up && !dn, "R4", "no pulse on coincident edges", int'(up | dn), 0);
    chk(lock == 1'b1, "R4", "lock after zero error", int'(lock), 1);
    ref_div  = 1'b0;
    main_div = 1'b0;
    @(negedge clk);

    // R7: width 1 is inside the window, width 2 sits on it
    run_cmp(0, 4, 1'b0, "R7");
    run_cmp(0, 1, 1'b1, "R7");
    run_cmp(1, 2, 1'b0, "R7");
    run_cmp(1, 1, 1'b1, "R7");

    // R6: a second reference edge inside a source pulse is ignored
    begin
      pulse_t e;
      e.is_up = 1'b1; e.width = 6; e.req = "R6";
      exp_q.push_back(e);
    end
    ref_div = 1'b1;
    repeat (2) @(negedge clk);
    ref_div = 1'b0;
    repeat (2) @(negedge clk);
    ref_div = 1'b1;
    repeat (2) @(negedge clk);
    main_div = 1'b1;
    @(negedge clk);
    chk(lock == 1'b0, "R6", "lock after extended pulse", int'(lock), 0);
    ref_div = 1'b0; main_div = 1'b0;
    @(negedge clk);

    // R8: disabled monitor forces the flag high, re-enable shows last verdict
    run_cmp(0, 1, 1'b1, "R8");
    lock_en = 1'b0;
    @(negedge clk);
    chk(lock == 1'b1, "R8", "lock forced high when disabled", int'(lock), 1);
    run_cmp(1, 5, 1'b1, "R8");
    lock_en = 1'b1;
    @(negedge clk);
    chk(lock == 1'b0, "R8", "lock shows last verdict on enable", int'(lock), 0);

    // R10: power pin dropped mid-pulse, pulse keeps its full width
    run_cmp(0, 1, 1'b1, "R10");
    begin
      pulse_t e;
      e.is_up = 1'b1; e.width = 5; e.req = "R10";
      exp_q.push_back(e);
    end
    ref_div = 1'b1;
    repeat (2) @(negedge clk);
    pwr_pin = 1'b0;
    repeat (3) @(negedge clk);
    main_div = 1'b1;
    @(negedge clk);
    chk(lock == 1'b0, "R10", "verdict of pulse finished while off", int'(lock), 0);
    ref_div = 1'b0; main_div = 1'b0;
    pwr_cfg = 1'b0;
    @(negedge clk);

    // R9: powered off, edges start nothing and leave the flag alone
    main_div = 1'b1;
    repeat (2) @(negedge clk);
    chk(!up && !dn, "R9", "no pulse while off", int'(up | dn), 0);
    ref_div = 1'b1;
    @(negedge clk);
    chk(!up && !dn, "R9", "no pulse after second edge while off", int'(up | dn), 0);
    ref_div = 1'b0; main_div = 1'b0;
    @(negedge clk);
    ref_div = 1'b1; main_div = 1'b1;
    @(negedge clk);
    chk(lock == 1'b0, "R9", "coincident edges not counted while off", int'(lock), 0);
    ref_div = 1'b0; main_div = 1'b0;
    pwr_pin = 1'b1;
    pwr_cfg = 1'b1;
    @(negedge clk);

    // R2: powered again, detection resumes
    run_cmp(0, 1, 1'b1, "R2");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "expected pulses left unseen", exp_q.size(), 0);
    finish_run();
  end

endmodule